// File: doc/BRIEF.md
# Cacheline Write Log Index

This block keeps the metadata for an append-only ring of 64-byte dirty cachelines. The ring lives in a device-side DRAM buffer that sits in front of flash, next to a separate page-granularity cache. Every host write takes the next ring slot, even when that line is already logged. A two-level index, first by page number and then by line offset within the page, always points at the newest slot for each line. Read lookups use that index to find the current copy.

When the ring fills up, a compaction engine drains it from the oldest end. Ring entries that the index no longer points to are released without output. The first live entry names a page. The engine then streams one header beat with that page number, followed by one beat per dirty line of that page, each giving the line offset and its log slot. This stream is the gather list for a single page-sized flash write. Payload storage, the flash side and the page cache belong to other blocks.

Top module: `cwl_write_log`

## Requirements
- R1: After reset `wr_ready` is 1, `cmp_valid` is 0, and every lookup misses.
- R2: An append is accepted on a cycle where `wr_valid` and `wr_ready` are both 1. The slot it takes is the value on `wr_slot` in that cycle. Slots are handed out in increasing order from 0 and wrap modulo 2^SLOT_W.
- R3: The ring counts both live and stale entries. While it holds 2^SLOT_W entries, `wr_ready` is 0.
- R4: A lookup presented with `rd_valid` returns its result one cycle later, with `rd_done`=1. `rd_hit` is 1 and `rd_slot` is the newest slot when the page/line is logged. Otherwise `rd_hit` is 0.
- R5: Writing a line that is already logged takes a new slot and repoints the index, so later lookups return the new slot.
- R6: A lookup in the same cycle as an accepted append to the same page and line returns hit with the slot being appended.
- R7: Compaction starts once occupancy is at least `hi_mark`. Each page flush begins with a header beat: `cmp_hdr`=1, and `cmp_page` holds the page of the oldest live entry.
- R8: After the header, one beat is emitted for each dirty line of that page, in ascending line order. Each beat carries `cmp_line`, the newest `cmp_slot` and `cmp_page`. `cmp_last` marks the final beat. After that, lookups to the page miss.
- R9: A ring entry at the oldest end that the index no longer points to is freed without producing any beat.
- R10: Compaction stops when occupancy drops below `lo_mark`. Pages still held in the ring stay logged and keep hitting.
- R11: While line beats of a page are being produced (every beat except the last), `wr_ready` is 0.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_mark | input | SLOT_W+1 | Occupancy at which compaction starts |
| lo_mark | input | SLOT_W+1 | Compaction continues while occupancy is at least this value |
| wr_valid | input | 1 | Append request |
| wr_ready | output | 1 | Append can be accepted |
| wr_page | input | PAGE_W | Page number of the written line |
| wr_line | input | LINE_W | Line offset within the page |
| wr_slot | output | SLOT_W | Ring slot that the current append takes |
| rd_valid | input | 1 | Lookup request |
| rd_page | input | PAGE_W | Lookup page |
| rd_line | input | LINE_W | Lookup line offset |
| rd_done | output | 1 | Lookup result valid (registered) |
| rd_hit | output | 1 | Line is logged |
| rd_slot | output | SLOT_W | Newest slot of the line |
| cmp_valid | output | 1 | Compaction beat valid |
| cmp_hdr | output | 1 | Beat is a page header |
| cmp_page | output | PAGE_W | Page being flushed |
| cmp_line | output | LINE_W | Line offset (line beats) |
| cmp_slot | output | SLOT_W | Slot holding that line (line beats) |
| cmp_last | output | 1 | Final line beat of the page |

## Verification
The bench targets a line that is rewritten before compaction reaches it. The oldest copy must be dropped silently and the page flushed once with only the newest slot. A design that emitted stale entries would produce a duplicate header or a wrong slot.

Several boundaries are covered. Filling the ring exactly to capacity tests back-pressure. An append after a drain tests slot wraparound. A lookup that races an append of the same line must return the new slot, not the old slot or a miss. Compaction is started with occupancy equal to the high mark and must stop precisely when occupancy falls below the low mark, so an off-by-one in either comparison shows up as a missing or extra page in the expected beat stream. The bench also requires `wr_ready` to be low on mid-page line beats, which catches an engine that lets appends alter the page while its line list is being read out.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  typedef enum logic [1:0] {
    CMP_IDLE,
    CMP_SCAN,
    CMP_LOAD,
    CMP_BEAT
  } cmp_state_e;
endpackage

// File: rtl/cwl_ring.sv
// Ring of slot metadata (page, line) with head, tail and occupancy.
module cwl_ring #(
  parameter int SLOT_W = 4,
  parameter int PAGE_W = 12,
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [PAGE_W-1:0] push_page,
  input  logic [LINE_W-1:0] push_line,
  input  logic              pop,
  output logic [SLOT_W-1:0] head,
  output logic [SLOT_W-1:0] tail,
  output logic [SLOT_W:0]   count,
  output logic [PAGE_W-1:0] tail_page,
  output logic [LINE_W-1:0] tail_line
);
  localparam int DEPTH = 1 << SLOT_W;

  logic [PAGE_W-1:0] meta_page [DEPTH];
  logic [LINE_W-1:0] meta_line [DEPTH];

  always_ff @(posedge clk) begin
    if (push) begin
      meta_page[head] <= push_page;
      meta_line[head] <= push_line;
    end
  end

  assign tail_page = meta_page[tail];
  assign tail_line = meta_line[tail];

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) head <= head + 1'b1;
      if (pop)  tail <= tail + 1'b1;
      count <= count + (SLOT_W+1)'(push) - (SLOT_W+1)'(pop);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    push |-> count != (SLOT_W+1)'(DEPTH));
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0);
endmodule

// File: rtl/cwl_index.sv
// Two-level index: page directory, then per-line valid bit and slot.
module cwl_index #(
  parameter int SLOT_W = 4,
  parameter int PAGE_W = 12,
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_en,
  input  logic [PAGE_W-1:0] ins_page,
  input  logic [LINE_W-1:0] ins_line,
  input  logic [SLOT_W-1:0] ins_slot,
  input  logic [PAGE_W-1:0] q_page,
  input  logic [LINE_W-1:0] q_line,
  output logic              q_hit,
  output logic [SLOT_W-1:0] q_slot,
  input  logic [PAGE_W-1:0] t_page,
  input  logic [LINE_W-1:0] t_line,
  output logic              t_hit,
  output logic [SLOT_W-1:0] t_slot,
  output logic [SLOT_W-1:0] t_ent,
  output logic [(1<<LINE_W)-1:0] t_mask,
  input  logic [SLOT_W-1:0] f_ent,
  input  logic [LINE_W-1:0] f_line,
  output logic [SLOT_W-1:0] f_slot,
  input  logic              clr_en,
  input  logic [SLOT_W-1:0] clr_ent
);
  localparam int NDIR  = 1 << SLOT_W;
  localparam int LINES = 1 << LINE_W;

  logic [NDIR-1:0]   dir_vld;
  logic [PAGE_W-1:0] dir_page [NDIR];
  logic [LINES-1:0]  line_vld [NDIR];
  logic [SLOT_W-1:0] slot_mem [NDIR*LINES];

  logic              q_f, t_f, i_f;
  logic [SLOT_W-1:0] q_e, t_e, i_e, fr_e, ins_ent;

  always_comb begin
    q_f = 1'b0; t_f = 1'b0; i_f = 1'b0;
    q_e = '0;   t_e = '0;   i_e = '0;   fr_e = '0;
    for (int e = NDIR-1; e >= 0; e--) begin
      if (dir_vld[e] && dir_page[e] == q_page)   begin q_f = 1'b1; q_e = SLOT_W'(e); end
      if (dir_vld[e] && dir_page[e] == t_page)   begin t_f = 1'b1; t_e = SLOT_W'(e); end
      if (dir_vld[e] && dir_page[e] == ins_page) begin i_f = 1'b1; i_e = SLOT_W'(e); end
      if (!dir_vld[e]) fr_e = SLOT_W'(e);
    end
  end

  assign ins_ent = i_f ? i_e : fr_e;
  assign q_hit   = q_f && line_vld[q_e][q_line];
  assign q_slot  = slot_mem[{q_e, q_line}];
  assign t_hit   = t_f && line_vld[t_e][t_line];
  assign t_slot  = slot_mem[{t_e, t_line}];
  assign t_ent   = t_e;
  assign t_mask  = line_vld[t_e];
  assign f_slot  = slot_mem[{f_ent, f_line}];

  always_ff @(posedge clk) begin
    if (ins_en) slot_mem[{ins_ent, ins_line}] <= ins_slot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_vld <= '0;
      for (int e = 0; e < NDIR; e++) line_vld[e] <= '0;
    end else begin
      if (ins_en) begin
        dir_vld[ins_ent]            <= 1'b1;
        dir_page[ins_ent]           <= ins_page;
        line_vld[ins_ent][ins_line] <= 1'b1;
      end
      if (clr_en) begin
        dir_vld[clr_ent]  <= 1'b0;
        line_vld[clr_ent] <= '0;
      end
    end
  end

  // A new page always finds a free directory entry (R2).
  assert_dir_room_R2: assert property (@(posedge clk) disable iff (rst)
    ins_en |-> (i_f || !(&dir_vld)));
  assert_no_clr_race_R11: assert property (@(posedge clk) disable iff (rst)
    !(ins_en && clr_en));
endmodule

// File: rtl/cwl_compactor.sv
// Drains the ring from the tail: frees stale entries, streams one page at a time.
module cwl_compactor
  import cwl_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int PAGE_W = 12,
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W:0]   count,
  input  logic [SLOT_W:0]   hi_mark,
  input  logic [SLOT_W:0]   lo_mark,
  input  logic              tail_live,
  input  logic [PAGE_W-1:0] tail_page,
  input  logic [SLOT_W-1:0] t_ent,
  input  logic [(1<<LINE_W)-1:0] t_mask,
  input  logic [SLOT_W-1:0] f_slot,
  output logic [SLOT_W-1:0] f_ent,
  output logic [LINE_W-1:0] f_line,
  output logic              pop,
  output logic              clr_en,
  output logic              hold_wr,
  output logic              cmp_valid,
  output logic              cmp_hdr,
  output logic [PAGE_W-1:0] cmp_page,
  output logic [LINE_W-1:0] cmp_line,
  output logic [SLOT_W-1:0] cmp_slot,
  output logic              cmp_last
);
  localparam int LINES = 1 << LINE_W;

  cmp_state_e        state;
  logic [LINES-1:0]  mask;
  logic [SLOT_W-1:0] ent;
  logic [LINE_W-1:0] pick;
  logic              last, go_on;

  always_comb begin
    pick = '0;
    for (int l = LINES-1; l >= 0; l--) if (mask[l]) pick = LINE_W'(l);
  end

  assign last    = (mask & (mask - 1'b1)) == '0;
  assign go_on   = (count != '0) && (count >= lo_mark);
  assign f_ent   = ent;
  assign f_line  = pick;
  assign pop     = (state == CMP_SCAN) && go_on && !tail_live;
  assign clr_en  = (state == CMP_BEAT) && last;
  assign hold_wr = (state == CMP_LOAD) || (state == CMP_BEAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CMP_IDLE;
      mask      <= '0;
      ent       <= '0;
      cmp_valid <= 1'b0;
      cmp_hdr   <= 1'b0;
      cmp_page  <= '0;
      cmp_line  <= '0;
      cmp_slot  <= '0;
      cmp_last  <= 1'b0;
    end else begin
      cmp_valid <= 1'b0;
      unique case (state)
        CMP_IDLE: if (count != '0 && count >= hi_mark) state <= CMP_SCAN;
        CMP_SCAN: begin
          if (!go_on) state <= CMP_IDLE;
          else if (tail_live) begin
            cmp_valid <= 1'b1;
            cmp_hdr   <= 1'b1;
            cmp_last  <= 1'b0;
            cmp_page  <= tail_page;
            state     <= CMP_LOAD;
          end
        end
        CMP_LOAD: begin
          ent   <= t_ent;
          mask  <= t_mask;
          state <= CMP_BEAT;
        end
        CMP_BEAT: begin
          cmp_valid  <= 1'b1;
          cmp_hdr    <= 1'b0;
          cmp_line   <= pick;
          cmp_slot   <= f_slot;
          cmp_last   <= last;
          mask[pick] <= 1'b0;
          if (last) state <= CMP_SCAN;
        end
        default: state <= CMP_IDLE;
      endcase
    end
  end

  assert_live_page_R8: assert property (@(posedge clk) disable iff (rst)
    (state == CMP_BEAT) |-> mask != '0);
  assert_last_ends_page_R8: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_last) |=> !(cmp_valid && !cmp_hdr));
  assert_hdr_above_low_R10: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_hdr) |-> $past(count >= lo_mark));
endmodule

// File: rtl/cwl_write_log.sv
module cwl_write_log #(
  parameter int SLOT_W = 4,
  parameter int PAGE_W = 12,
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W:0]   hi_mark,
  input  logic [SLOT_W:0]   lo_mark,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic [LINE_W-1:0] wr_line,
  output logic [SLOT_W-1:0] wr_slot,
  input  logic              rd_valid,
  input  logic [PAGE_W-1:0] rd_page,
  input  logic [LINE_W-1:0] rd_line,
  output logic              rd_done,
  output logic              rd_hit,
  output logic [SLOT_W-1:0] rd_slot,
  output logic              cmp_valid,
  output logic              cmp_hdr,
  output logic [PAGE_W-1:0] cmp_page,
  output logic [LINE_W-1:0] cmp_line,
  output logic [SLOT_W-1:0] cmp_slot,
  output logic              cmp_last
);
  localparam int DEPTH = 1 << SLOT_W;
  localparam int LINES = 1 << LINE_W;

  logic              wr_fire, pop, clr_en, hold_wr;
  logic [SLOT_W-1:0] head, tail, t_ent, t_slot, q_slot, f_ent, f_slot;
  logic [SLOT_W:0]   count;
  logic [PAGE_W-1:0] tail_page;
  logic [LINE_W-1:0] tail_line, f_line;
  logic [LINES-1:0]  t_mask;
  logic              q_hit, t_hit, same_line;

  assign wr_ready  = (count != (SLOT_W+1)'(DEPTH)) && !hold_wr;
  assign wr_fire   = wr_valid && wr_ready;
  assign wr_slot   = head;
  assign same_line = wr_fire && (wr_page == rd_page) && (wr_line == rd_line);

  cwl_ring #(.SLOT_W(SLOT_W), .PAGE_W(PAGE_W), .LINE_W(LINE_W)) u_ring (
    .clk(clk), .rst(rst), .push(wr_fire), .push_page(wr_page), .push_line(wr_line),
    .pop(pop), .head(head), .tail(tail), .count(count),
    .tail_page(tail_page), .tail_line(tail_line)
  );

  cwl_index #(.SLOT_W(SLOT_W), .PAGE_W(PAGE_W), .LINE_W(LINE_W)) u_index (
    .clk(clk), .rst(rst),
    .ins_en(wr_fire), .ins_page(wr_page), .ins_line(wr_line), .ins_slot(head),
    .q_page(rd_page), .q_line(rd_line), .q_hit(q_hit), .q_slot(q_slot),
    .t_page(tail_page), .t_line(tail_line), .t_hit(t_hit), .t_slot(t_slot),
    .t_ent(t_ent), .t_mask(t_mask),
    .f_ent(f_ent), .f_line(f_line), .f_slot(f_slot),
    .clr_en(clr_en), .clr_ent(f_ent)
  );

  cwl_compactor #(.SLOT_W(SLOT_W), .PAGE_W(PAGE_W), .LINE_W(LINE_W)) u_cmp (
    .clk(clk), .rst(rst), .count(count), .hi_mark(hi_mark), .lo_mark(lo_mark),
    .tail_live(t_hit && (t_slot == tail)), .tail_page(tail_page),
    .t_ent(t_ent), .t_mask(t_mask), .f_slot(f_slot), .f_ent(f_ent), .f_line(f_line),
    .pop(pop), .clr_en(clr_en), .hold_wr(hold_wr),
    .cmp_valid(cmp_valid), .cmp_hdr(cmp_hdr), .cmp_page(cmp_page),
    .cmp_line(cmp_line), .cmp_slot(cmp_slot), .cmp_last(cmp_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_done <= 1'b0;
      rd_hit  <= 1'b0;
      rd_slot <= '0;
    end else begin
      rd_done <= rd_valid;
      rd_hit  <= rd_valid && (same_line || q_hit);
      rd_slot <= same_line ? head : q_slot;
    end
  end

  assert_same_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && same_line) |=> (rd_hit && rd_slot == $past(wr_slot)));
  assert_full_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (count == (SLOT_W+1)'(DEPTH)) |-> !wr_ready);
endmodule

// File: tb/cwl_write_log_test.sv
module cwl_write_log_test;
  localparam int SW = 4, PW = 12, LW = 6;
  localparam int BW = 1 + PW + LW + SW + 1;

  logic clk = 0, rst = 1;
  logic [SW:0] hi_mark = 5'd31, lo_mark = 5'd0;
  logic wr_valid = 0, rd_valid = 0;
  logic [PW-1:0] wr_page = '0, rd_page = '0;
  logic [LW-1:0] wr_line = '0, rd_line = '0;
  logic wr_ready, rd_done, rd_hit, cmp_valid, cmp_hdr, cmp_last;
  logic [SW-1:0] wr_slot, rd_slot, cmp_slot;
  logic [PW-1:0] cmp_page;
  logic [LW-1:0] cmp_line;

  int checks = 0, errors = 0, beats = 0;
  bit done = 0;
  logic [BW-1:0] exp_q[$];

  always #5 clk = ~clk;

  cwl_write_log #(.SLOT_W(SW), .PAGE_W(PW), .LINE_W(LW)) uut (
    .clk(clk), .rst(rst), .hi_mark(hi_mark), .lo_mark(lo_mark),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_page(wr_page), .wr_line(wr_line),
    .wr_slot(wr_slot), .rd_valid(rd_valid), .rd_page(rd_page), .rd_line(rd_line),
    .rd_done(rd_done), .rd_hit(rd_hit), .rd_slot(rd_slot),
    .cmp_valid(cmp_valid), .cmp_hdr(cmp_hdr), .cmp_page(cmp_page),
    .cmp_line(cmp_line), .cmp_slot(cmp_slot), .cmp_last(cmp_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_hdr(input int p);
    exp_q.push_back({1'b1, PW'(p), LW'(0), SW'(0), 1'b0});
  endtask

  task automatic expect_line(input int p, input int l, input int s, input bit last);
    exp_q.push_back({1'b0, PW'(p), LW'(l), SW'(s), last});
  endtask

  // Monitor: pops expected beats and compares; checks mid-page stall.
  always @(negedge clk) begin
    if (!rst && cmp_valid) begin
      logic [BW-1:0] got;
      got = {cmp_hdr, cmp_page, cmp_hdr ? LW'(0) : cmp_line,
             cmp_hdr ? SW'(0) : cmp_slot, cmp_last};
      beats++;
      if (exp_q.size() == 0) check("R9 unexpected beat", 32'(got), 32'hFFFF_FFFF);
      else check("R7/R8 beat", 32'(got), 32'(exp_q.pop_front()));
      if (!cmp_hdr && !cmp_last) check("R11 wr_ready during line beats", 32'(wr_ready), 0);
    end
  end

  task automatic append(input int p, input int l, input int s, input string req);
    @(negedge clk);
    wr_valid = 1; wr_page = PW'(p); wr_line = LW'(l);
    check({req, " ready"}, 32'(wr_ready), 1);
    check({req, " slot"}, 32'(wr_slot), 32'(s));
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic lookup(input int p, input int l, input bit hit, input int s, input string req);
    @(negedge clk);
    rd_valid = 1; rd_page = PW'(p); rd_line = LW'(l);
    @(negedge clk);
    rd_valid = 0;
    check({req, " done"}, 32'(rd_done), 1);
    check({req, " hit"}, 32'(rd_hit), 32'(hit));
    if (hit) check({req, " slot"}, 32'(rd_slot), 32'(s));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    @(negedge clk);
    check("R1 wr_ready", 32'(wr_ready), 1);
    check("R1 cmp_valid", 32'(cmp_valid), 0);
    lookup(5, 3, 0, 0, "R1 empty lookup");

    // R2 sequential slots, R5 rewrite
    append(5, 3, 0, "R2");
    append(5, 7, 1, "R2");
    append(9, 0, 2, "R2");
    append(5, 3, 3, "R5");
    lookup(5, 3, 1, 3, "R5 newest wins");
    lookup(5, 7, 1, 1, "R4");
    lookup(9, 0, 1, 2, "R4");
    lookup(9, 1, 0, 0, "R4 miss line");
    lookup(6, 3, 0, 0, "R4 miss page");

    // R6 same-cycle append and lookup
    @(negedge clk);
    wr_valid = 1; wr_page = 9; wr_line = 1;
    rd_valid = 1; rd_page = 9; rd_line = 1;
    check("R6 slot", 32'(wr_slot), 4);
    @(negedge clk);
    wr_valid = 0; rd_valid = 0;
    check("R6 hit", 32'(rd_hit), 1);
    check("R6 slot", 32'(rd_slot), 4);

    // Fill to capacity: pages 20..30 take slots 5..15
    for (int k = 0; k < 11; k++) append(20 + k, 0, 5 + k, "R2 fill");
    @(negedge clk);
    check("R3 full stall", 32'(wr_ready), 0);

    // R7-R10: compaction from 16 entries down to below 13
    expect_hdr(5);
    expect_line(5, 3, 3, 0);
    expect_line(5, 7, 1, 1);
    expect_hdr(9);
    expect_line(9, 0, 2, 0);
    expect_line(9, 1, 4, 1);
    hi_mark = 5'd16; lo_mark = 5'd13;
    repeat (150) @(negedge clk);
    check("R7 all beats seen", 32'(exp_q.size()), 0);
    check("R9 beat count", 32'(beats), 6);
    check("R10 stopped, space free", 32'(wr_ready), 1);
    lookup(5, 3, 0, 0, "R8 flushed page");
    lookup(9, 1, 0, 0, "R8 flushed page");
    lookup(20, 0, 1, 5, "R10 unflushed page");

    // R2 wraparound, R3 full again
    hi_mark = 5'd31;
    for (int k = 0; k < 4; k++) append(40 + k, 2, k, "R2 wrap");
    @(negedge clk);
    check("R3 full after wrap", 32'(wr_ready), 0);
    lookup(40, 2, 1, 0, "R4 wrapped slot");
    repeat (20) @(negedge clk);
    check("R10 no beats below high mark", 32'(beats), 6);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule